// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the current word address for a synchronous burst memory. When either of two address strobes is seen on a rising clock edge, it captures a base address. It then walks the low offset bits of that address through a four-beat burst, one step on each cycle where the advance input is high. The high address bits are taken from the captured base and never change within a burst.

A static mode pin chooses the beat order. Linear order adds the beat count to the starting offset, modulo the burst length. Interleaved order XORs the starting offset with the beat count. After the last beat the sequence comes back to the starting offset, and a wrap flag marks that return for one cycle. The block has no data path. All of its pins are plain control and status signals, with no valid/ready handshake and no back-pressure.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `cur_addr` is 0 and `wrap` is 0.
- R2: A rising edge where `strobe_cpu` or `strobe_ctl` is 1 captures `base_addr`. From that edge on, `cur_addr` equals the captured address and the beat count restarts at 0. Either strobe alone is enough.
- R3: A rising edge with no strobe and `adv`=1 moves the beat count one step, modulo 4.
- R4: A rising edge with no strobe and `adv`=0 leaves `cur_addr` and the beat count unchanged. This inserts wait cycles.
- R5: With `mode_ilv`=0 (linear), the low 2 bits of `cur_addr` are (start offset + beat count) mod 4.
- R6: With `mode_ilv`=1 (interleaved), the low 2 bits of `cur_addr` are (start offset XOR beat count).
- R7: After the fourth advance, `cur_addr` returns to the captured address and the upper bits never carry. `wrap` is 1 in exactly the cycle after the edge on which the count went from 3 to 0, and 0 in all other cycles.
- R8: A strobe on the same edge as `adv`=1 reloads the address and restarts the count, and the advance is ignored. No wrap is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ilv | input | 1 | Beat order: 0 linear, 1 interleaved |
| strobe_cpu | input | 1 | First address strobe, active high |
| strobe_ctl | input | 1 | Second address strobe, active high |
| adv | input | 1 | Advance the beat count |
| base_addr | input | ADDR_W | Address captured on a strobe |
| cur_addr | output | ADDR_W | Current burst address |
| wrap | output | 1 | One-cycle pulse when the burst returns to its start |

## Verification
The bench builds the block with ADDR_W=8 and CNT_W=2, which keeps the whole offset space small. It can then sweep every start offset under both orders and both strobe sources, with several upper-bit patterns. Each burst runs through all four beats and past the wrap, with a wait cycle in the middle, and ends with a strobe that collides with an advance.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  output logic [CNT_W-1:0] beat,
  output logic             wrapped
);
  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat    <= '0;
      wrapped <= 1'b0;
    end else if (load) begin
      beat    <= '0;
      wrapped <= 1'b0;
    end else begin
      if (step) beat <= beat + 1'b1;
      wrapped <= step && (beat == LAST);
    end
  end

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (beat == '0) && !wrapped); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step) |=> beat == $past(beat) + 1'b1); // R3
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(beat)); // R4
  AST_WRAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrapped |-> beat == '0); // R7
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  burst_order_e     order,
  input  logic [CNT_W-1:0] start,
  input  logic [CNT_W-1:0] beat,
  output logic [CNT_W-1:0] offset
);
  logic [CNT_W-1:0] lin_off;
  logic [CNT_W-1:0] xor_off;

  assign lin_off = start + beat;

  for (genvar b = 0; b < CNT_W; b++) begin : g_xor
    assign xor_off[b] = start[b] ^ beat[b];
  end

  always_comb begin
    offset = (order == ORDER_XOR) ? xor_off : lin_off;
  end

  always_comb begin
    if (beat == '0) begin
      AST_BEAT0_IS_START: assert (offset == start); // R2
    end
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ilv,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              adv,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wrap
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic              load;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  beat;
  logic [CNT_W-1:0]  offset;
  burst_order_e      order;

  assign load  = strobe_cpu | strobe_ctl;
  assign order = burst_order_e'(mode_ilv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= base_addr;
  end

  burst_beat_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(load), .step(adv),
    .beat(beat), .wrapped(wrap)
  );

  burst_offset_map #(.CNT_W(CNT_W)) map_i (
    .order(order), .start(base_q[CNT_W-1:0]), .beat(beat), .offset(offset)
  );

  assign cur_addr = {base_q[ADDR_W-1:CNT_W], offset};

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur_addr == $past(base_addr)); // R2
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cur_addr[ADDR_W-1:CNT_W] == $past(cur_addr[ADDR_W-1:CNT_W])); // R7
  AST_WAIT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv && $stable(mode_ilv)) |=> $stable(cur_addr)); // R4
  AST_WRAP_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> cur_addr == base_q); // R7

  initial begin
    assert (HI_W >= 0);
  end
endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
  localparam int AW = 8;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_ilv = 1'b0;
  logic          strobe_cpu = 1'b0;
  logic          strobe_ctl = 1'b0;
  logic          adv = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] cur_addr;
  logic          wrap;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_ilv(mode_ilv),
    .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .adv(adv),
    .base_addr(base_addr), .cur_addr(cur_addr), .wrap(wrap)
  );

  task automatic check(string req, logic [AW-1:0] exp_a, logic exp_w);
    checks++;
    if (cur_addr !== exp_a || wrap !== exp_w) begin
      errors++;
      $display("FAIL %s: addr=%h wrap=%b expected addr=%h wrap=%b",
               req, cur_addr, wrap, exp_a, exp_w);
    end
  endtask

  task automatic step(logic s_cpu, logic s_ctl, logic a, logic [AW-1:0] b);
    @(negedge clk);
    strobe_cpu = s_cpu; strobe_ctl = s_ctl; adv = a; base_addr = b;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] b, int k, logic ilv);
    logic [CW-1:0] lo;
    lo = ilv ? (b[CW-1:0] ^ CW'(k)) : CW'((int'(b[CW-1:0]) + k) % 4);
    return {b[AW-1:CW], lo};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", '0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", '0, 1'b0);

    for (int m = 0; m < 2; m++) begin
      for (int src = 0; src < 2; src++) begin
        for (int lo = 0; lo < 4; lo++) begin
          logic [AW-1:0] b;
          logic [AW-1:0] b2;
          b = AW'((((m * 2 + src) * 4 + lo) * 37 + 8) & 8'hFC) | AW'(lo);
          @(negedge clk); mode_ilv = m[0];
          step(src == 0, src == 1, 1'b0, b);
          check("R2 load", b, 1'b0);
          for (int k = 1; k <= 4; k++) begin
            if (k == 2) begin
              step(1'b0, 1'b0, 1'b0, ~b);
              check("R4 wait holds", expect_addr(b, 1, m[0]), 1'b0);
            end
            step(1'b0, 1'b0, 1'b1, ~b);
            if (k == 4)
              check("R7 wrap to base", b, 1'b1);
            else if (m == 0)
              check("R5 R3 linear beat", expect_addr(b, k, 1'b0), 1'b0);
            else
              check("R6 R3 interleaved beat", expect_addr(b, k, 1'b1), 1'b0);
          end
          step(1'b0, 1'b0, 1'b1, ~b);
          check("R7 past wrap", expect_addr(b, 1, m[0]), 1'b0);
          b2 = b ^ 8'h5A;
          step(src == 1, src == 0, 1'b1, b2);
          check("R8 strobe beats advance", b2, 1'b0);
          step(1'b0, 1'b0, 1'b1, b);
          check("R8 burst restarted", expect_addr(b2, 1, m[0]), 1'b0);
        end
      end
    end

    step(1'b1, 1'b1, 1'b0, 8'hA7);
    check("R2 both strobes", 8'hA7, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule